// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the processor side of a coprocessor attachment. The decode and condition logic tell it that a coprocessor instruction is in the execute stage and that it is really going to execute. The block then lowers an active-low strobe that all attached coprocessors watch. On every clock after that it samples their absent and busy answers, merged into one response. From that response it holds the pipeline stalled, asks for an undefined-instruction trap, or issues a one-cycle commit pulse.

An interrupt or flush that arrives during the wait abandons the handshake quietly. A stall watchdog with a parameterised limit ends a handshake whose coprocessor never stops answering busy, and reports it with a one-cycle error pulse. Condition evaluation, the trap handler and the coprocessors themselves are outside the block.

Top module: `cp_handshake_seq`

## Requirements
- R1: After reset the strobe is high, the stall output is low and the trap, commit and watchdog-error pulses are low.
- R2: The strobe goes low in the cycle after a clock edge that sees the instruction flag and the condition-passed flag both high while the block is idle. If either flag is low the strobe stays high.
- R3: If at a clock edge with the strobe low every absent line is high, the next cycle shows a one-cycle trap pulse with the strobe high and no commit.
- R4: If at a clock edge with the strobe low some coprocessor has its absent line low and its busy line high, the strobe stays low and the stall stays high for the next cycle with no outcome pulse. The response is sampled again at the following edge.
- R5: If at a clock edge with the strobe low the claiming coprocessor (absent low) shows busy low, the next cycle shows a one-cycle commit pulse with stall low and the strobe high.
- R6: The merged absent is the AND of all absent lines. The merged busy takes busy only from coprocessors whose absent line is low, so a busy line raised by an absent coprocessor has no effect on the outcome.
- R7: A flush seen at a clock edge with the strobe low ends the handshake. The next cycle has the strobe high, stall low and no trap, commit or error pulse.
- R8: With limit L (parameter STALL_LIMIT), up to L busy samples in one handshake keep it stalled. A further busy sample ends it with a one-cycle watchdog-error pulse, the strobe high and no commit or trap.
- R9: At most one of trap, commit and watchdog error is high in any cycle. In the cycle that shows an outcome, a request still held high does not start a new handshake.
- R10: A flush seen at the same edge as a request in the idle state stops the handshake from starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_insn_i | input | 1 | Coprocessor instruction in execute |
| cond_pass_i | input | 1 | The instruction's condition passed |
| flush_i | input | 1 | Interrupt or pipeline flush, cancels a handshake |
| cp_absent_i | input | N_CP | Per-coprocessor absent lines, high means "not mine" |
| cp_busy_i | input | N_CP | Per-coprocessor busy lines |
| cp_strobe_n_o | output | 1 | Active-low coprocessor instruction strobe |
| stall_o | output | 1 | Pipeline stall while the handshake is pending |
| trap_o | output | 1 | One-cycle undefined-instruction trap request |
| commit_o | output | 1 | One-cycle commit pulse |
| wd_err_o | output | 1 | One-cycle stall watchdog error pulse |

## Verification
The checker assumes that at most one coprocessor lowers its absent line for a given instruction. It also assumes that the instruction flag stays high while the stall is up and that every input is a defined value at each sampling edge. The stimulus claims with a one-hot absent pattern or with all lines high, raises random busy noise only on coprocessors that are absent, and drops the request one cycle after an outcome. Random transactions from a fixed seed mix busy lengths up to two beyond the limit, random claimers, all-absent cases and flushes at random sample indices. Directed cases cover failed conditions and a flush in the idle state.

// File: rtl/cp_hs_pkg.sv
package cp_hs_pkg;

   typedef enum logic [0:0] {
      HS_IDLE = 1'b0,
      HS_WAIT = 1'b1
   } hs_state_e;

   // merged coprocessor answer for one sampling edge
   typedef struct packed {
      logic absent;
      logic busy;
   } cp_resp_t;

endpackage

// File: rtl/cp_resp_merge.sv
module cp_resp_merge
   import cp_hs_pkg::*;
#(
   parameter int N_CP            = 4,
   parameter bit CLAIM_ONLY_BUSY = 1'b1
) (
   input  logic [N_CP-1:0] absent_i,
   input  logic [N_CP-1:0] busy_i,
   output cp_resp_t        resp_o
);

   generate
      if (N_CP < 1) begin : g_bad_count
         $error("cp_resp_merge: N_CP must be at least 1");
      end

      if (N_CP == 1) begin : g_single
         assign resp_o.absent = absent_i[0];
         assign resp_o.busy   = CLAIM_ONLY_BUSY ? (busy_i[0] & ~absent_i[0]) : busy_i[0];
      end else begin : g_multi
         logic [N_CP-1:0] claim_busy;
         for (genvar i = 0; i < N_CP; i++) begin : g_lane
            if (CLAIM_ONLY_BUSY) begin : g_claim
               assign claim_busy[i] = busy_i[i] & ~absent_i[i];
            end else begin : g_any
               assign claim_busy[i] = busy_i[i];
            end
         end
         assign resp_o.absent = &absent_i;
         assign resp_o.busy   = |claim_busy;
      end
   endgenerate

endmodule

// File: rtl/cp_stall_watchdog.sv
module cp_stall_watchdog #(
   parameter int STALL_LIMIT = 16,
   localparam int CNT_W      = $clog2(STALL_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic tick_i,
   output logic expire_o
);

   generate
      if (STALL_LIMIT < 1) begin : g_bad_limit
         $error("cp_stall_watchdog: STALL_LIMIT must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STALL_LIMIT);

   logic [CNT_W-1:0] busy_cnt;

   // a busy sample beyond the allowed count expires the handshake
   assign expire_o = tick_i && (busy_cnt == LIMIT_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (clear_i) begin
         busy_cnt <= '0;
      end else if (tick_i && (busy_cnt != LIMIT_V)) begin
         busy_cnt <= busy_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/cp_hs_fsm.sv
module cp_hs_fsm
   import cp_hs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_i,
   input  logic     flush_i,
   input  cp_resp_t resp_i,
   input  logic     expire_i,
   output logic     waiting_o,
   output logic     busy_tick_o,
   output logic     trap_o,
   output logic     commit_o,
   output logic     wd_err_o
);

   hs_state_e state_q, state_d;
   logic      done_q, done_d;
   logic      trap_d, commit_d, err_d;

   always_comb begin
      state_d  = state_q;
      done_d   = 1'b0;
      trap_d   = 1'b0;
      commit_d = 1'b0;
      err_d    = 1'b0;
      unique case (state_q)
         HS_IDLE: begin
            // the instruction just resolved is still in execute while done_q is high
            if (req_i && !flush_i && !done_q) state_d = HS_WAIT;
         end
         HS_WAIT: begin
            if (flush_i) begin
               state_d = HS_IDLE;
               done_d  = 1'b1;
            end else if (resp_i.absent) begin
               state_d = HS_IDLE;
               done_d  = 1'b1;
               trap_d  = 1'b1;
            end else if (resp_i.busy) begin
               if (expire_i) begin
                  state_d = HS_IDLE;
                  done_d  = 1'b1;
                  err_d   = 1'b1;
               end
            end else begin
               state_d  = HS_IDLE;
               done_d   = 1'b1;
               commit_d = 1'b1;
            end
         end
         default: state_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= HS_IDLE;
         done_q   <= 1'b0;
         trap_o   <= 1'b0;
         commit_o <= 1'b0;
         wd_err_o <= 1'b0;
      end else begin
         state_q  <= state_d;
         done_q   <= done_d;
         trap_o   <= trap_d;
         commit_o <= commit_d;
         wd_err_o <= err_d;
      end
   end

   assign waiting_o   = (state_q == HS_WAIT);
   assign busy_tick_o = waiting_o && !flush_i && !resp_i.absent && resp_i.busy;

endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
   import cp_hs_pkg::*;
#(
   parameter int N_CP            = 4,
   parameter int STALL_LIMIT     = 16,
   parameter bit CLAIM_ONLY_BUSY = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cp_insn_i,
   input  logic            cond_pass_i,
   input  logic            flush_i,
   input  logic [N_CP-1:0] cp_absent_i,
   input  logic [N_CP-1:0] cp_busy_i,
   output logic            cp_strobe_n_o,
   output logic            stall_o,
   output logic            trap_o,
   output logic            commit_o,
   output logic            wd_err_o
);

   cp_resp_t resp;
   logic     waiting;
   logic     busy_tick;
   logic     expire;

   cp_resp_merge #(
      .N_CP           (N_CP),
      .CLAIM_ONLY_BUSY(CLAIM_ONLY_BUSY)
   ) u_merge (
      .absent_i(cp_absent_i),
      .busy_i  (cp_busy_i),
      .resp_o  (resp)
   );

   cp_stall_watchdog #(
      .STALL_LIMIT(STALL_LIMIT)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (!waiting),
      .tick_i  (busy_tick),
      .expire_o(expire)
   );

   cp_hs_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (cp_insn_i && cond_pass_i),
      .flush_i    (flush_i),
      .resp_i     (resp),
      .expire_i   (expire),
      .waiting_o  (waiting),
      .busy_tick_o(busy_tick),
      .trap_o     (trap_o),
      .commit_o   (commit_o),
      .wd_err_o   (wd_err_o)
   );

   assign cp_strobe_n_o = !waiting;
   assign stall_o       = waiting;

endmodule

// File: rtl/cp_hs_checker.sv
module cp_hs_checker #(
   parameter int N_CP        = 4,
   parameter int STALL_LIMIT = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cp_insn_i,
   input logic            cond_pass_i,
   input logic            flush_i,
   input logic [N_CP-1:0] cp_absent_i,
   input logic [N_CP-1:0] cp_busy_i,
   input logic            cp_strobe_n_o,
   input logic            stall_o,
   input logic            trap_o,
   input logic            commit_o,
   input logic            wd_err_o
);

   logic        all_absent;
   logic        claim_busy;
   int unsigned low_run;

   assign all_absent = &cp_absent_i;
   assign claim_busy = |(~cp_absent_i & cp_busy_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             low_run <= 0;
      else if (cp_strobe_n_o) low_run <= 0;
      else                    low_run <= low_run + 1;
   end

   a_r2_no_strobe_without_request: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_strobe_n_o && !(cp_insn_i && cond_pass_i)) |=> cp_strobe_n_o);

   a_r3_absent_traps: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (cp_strobe_n_o && !commit_o));

   a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_strobe_n_o && !flush_i && !all_absent && claim_busy)
         |=> (!commit_o && !trap_o));

   a_r5_commit_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o);

   a_r6_merged_absent_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_strobe_n_o && !flush_i && all_absent) |=> trap_o);

   a_r6_claim_idle_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_strobe_n_o && !flush_i && !all_absent && !claim_busy) |=> (commit_o && !stall_o));

   a_r7_flush_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_strobe_n_o && flush_i)
         |=> (cp_strobe_n_o && !commit_o && !trap_o && !wd_err_o));

   a_r8_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !cp_strobe_n_o |-> (low_run <= STALL_LIMIT));

   a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({trap_o, commit_o, wd_err_o}) <= 1);

   a_r10_flush_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_strobe_n_o && flush_i) |=> cp_strobe_n_o);

endmodule

bind cp_handshake_seq cp_hs_checker #(
   .N_CP       (N_CP),
   .STALL_LIMIT(STALL_LIMIT)
) u_chk (.*);

// File: tb/cp_handshake_seq_bench.sv
module cp_handshake_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N_CP       = 4;
   localparam int LIM        = 5;

   localparam logic [4:0] V_STALL  = 5'b01000;
   localparam logic [4:0] V_TRAP   = 5'b10100;
   localparam logic [4:0] V_COMMIT = 5'b10010;
   localparam logic [4:0] V_ERR    = 5'b10001;
   localparam logic [4:0] V_IDLE   = 5'b10000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cp_insn, cond_pass, flush;
   logic [N_CP-1:0] absent, busy;
   logic            strobe_n, stall, trap, commit, wd_err;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cp_handshake_seq #(
      .N_CP       (N_CP),
      .STALL_LIMIT(LIM)
   ) u_cp_handshake_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cp_insn_i    (cp_insn),
      .cond_pass_i  (cond_pass),
      .flush_i      (flush),
      .cp_absent_i  (absent),
      .cp_busy_i    (busy),
      .cp_strobe_n_o(strobe_n),
      .stall_o      (stall),
      .trap_o       (trap),
      .commit_o     (commit),
      .wd_err_o     (wd_err)
   );

   function automatic logic [4:0] outs();
      return {strobe_n, stall, trap, commit, wd_err};
   endfunction

   // expected outputs after one sampling edge, from the requirements
   function automatic logic [4:0] expect_after(input logic fl, input logic [N_CP-1:0] ab,
                                               input logic [N_CP-1:0] bz, input int prior_busy);
      if (fl) return V_IDLE;
      if (&ab) return V_TRAP;
      if (|(~ab & bz)) return (prior_busy >= LIM) ? V_ERR : V_STALL;
      return V_COMMIT;
   endfunction

   function automatic string tag_of(input logic [4:0] v);
      case (v)
         V_STALL:  return "R4";
         V_TRAP:   return "R3";
         V_COMMIT: return "R5";
         V_ERR:    return "R8";
         default:  return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: outputs {strobe_n,stall,trap,commit,err} got %b expected %b",
                  tag, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_idle();
      cp_insn = 1'b0; cond_pass = 1'b0; flush = 1'b0;
      absent = '1; busy = '0;
   endtask

   // one handshake; n_busy busy samples from the claimer, flush at sample fl_idx
   task automatic run_txn(input int n_busy, input bit all_abs, input int claimer,
                          input int fl_idx, input logic [N_CP-1:0] noise);
      logic [N_CP-1:0] oh;
      logic [4:0]      e;
      oh = N_CP'(1) << claimer;
      cp_insn = 1'b1; cond_pass = 1'b1;
      step();
      check("R2 strobe after request", outs(), V_STALL);
      for (int s = 0; s <= LIM + 2; s++) begin
         flush  = (s == fl_idx);
         absent = all_abs ? '1 : ~oh;
         busy   = all_abs ? noise : (((s < n_busy) ? oh : '0) | (noise & ~oh));
         e = expect_after(flush, absent, busy, s);
         step();
         flush = 1'b0;
         check((noise != '0 && e != V_IDLE) ? {tag_of(e), " R6"} : tag_of(e), outs(), e);
         if (e != V_STALL) break;
      end
      // request still held: must not restart in the outcome cycle
      step();
      check("R9 no restart on held request", outs(), V_IDLE);
      go_idle();
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240517));
      go_idle();
      repeat (3) @(negedge clk);
      check("R1 reset state", outs(), V_IDLE);
      rst_n = 1'b1;
      step();
      check("R1 after release", outs(), V_IDLE);

      // R2: condition failed, or not a coprocessor instruction
      cp_insn = 1'b1; cond_pass = 1'b0;
      step(); step();
      check("R2 cond failed keeps strobe high", outs(), V_IDLE);
      cp_insn = 1'b0; cond_pass = 1'b1;
      step();
      check("R2 no insn keeps strobe high", outs(), V_IDLE);
      go_idle();

      // R10: flush at request edge
      cp_insn = 1'b1; cond_pass = 1'b1; flush = 1'b1;
      step();
      check("R10 flush blocks start", outs(), V_IDLE);
      go_idle();
      step();

      // directed corners
      run_txn(0, 1'b0, 0, -1, '0);           // immediate commit R5
      run_txn(0, 1'b1, 0, -1, 4'b1010);      // all absent, busy noise R3 R6
      run_txn(3, 1'b0, 2, -1, 4'b1011);      // busy from absent units ignored R6
      run_txn(LIM, 1'b0, 1, -1, '0);         // exactly at limit, commits R8
      run_txn(LIM + 1, 1'b0, 3, -1, '0);     // one beyond, watchdog R8
      run_txn(4, 1'b0, 0, 2, '0);            // flush during stall R7
      run_txn(2, 1'b0, 1, 0, '0);            // flush at first sample R7

      for (int t = 0; t < 60; t++) begin
         int nb, cl, fi;
         bit aa;
         logic [N_CP-1:0] nz;
         nb = $urandom_range(LIM + 2, 0);
         cl = $urandom_range(N_CP - 1, 0);
         aa = ($urandom_range(7, 0) == 0);
         fi = ($urandom_range(5, 0) == 0) ? $urandom_range(LIM, 0) : -1;
         nz = N_CP'($urandom());
         run_txn(nb, aa, cl, fi, nz);
      end

      report();
      $finish;
   end

endmodule